// File: doc/BRIEF.md
# Multi-Input Edge Wake-Up Controller

This block watches sixteen asynchronous event lines, coming from pins or from other on-chip units, and turns a chosen edge on any of them into a recorded event. Each line is first brought into the clock domain through a two-stage synchronizer. It is then compared with its value in the previous cycle to find a rising or a falling edge, as its polarity bit selects. A detected edge sets that channel's pending bit. The pending bit stays set until software clears it by writing a one to it.

Each channel has a two-bit routing field that sends it to one of four interrupt lines. An interrupt line is active while any channel routed to it is both enabled and pending. A separate wake request is active while any enabled channel is pending, whatever its routing. Power-mode logic can use this request to leave a low-power state, and it needs no clock running at full speed to do so. A disabled channel still records its edges, so enabling it later raises the interrupt at once. Four word registers behind a simple write strobe and an address hold the enable mask, the polarity mask, the pending bits and the routing fields.

Top module: `edge_wake_ctrl`

## Requirements
- R1: After reset, the enable, polarity, pending and routing registers all read 0, every interrupt line is low and the wake request is low.
- R2: With its polarity bit at 0, a 0-to-1 change on a channel's input sets that channel's pending bit, and a 1-to-0 change does not.
- R3: With its polarity bit at 1, a 1-to-0 change sets the pending bit, and a 0-to-1 change does not.
- R4: A disabled channel (enable bit 0) still sets its pending bit on an edge, but drives no interrupt line and no wake request until it is enabled.
- R5: Interrupt line k is high exactly when some channel c has its enable and pending bits set and routing bits [2c+1:2c] equal k.
- R6: The wake request is high exactly when at least one channel is both enabled and pending.
- R7: Writing to the pending register (address 2) clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R8: When an edge is recorded in the same cycle as a write that clears that channel's pending bit, the bit ends up set.
- R9: Changing a channel's polarity bit while its input is steady does not set its pending bit.
- R10: An input that is held at 1 through reset and afterwards records no edge.
- R11: A change on an input sets the pending bit at the third rising clock edge after the change, and not before.

Register addresses: 0 is the enable mask, 1 is the polarity mask, 2 is the pending bits, and 3 holds the routing fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_in | input | 16 | Asynchronous event lines, one per channel |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 enable, 1 polarity, 2 pending, 3 routing |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register, combinational |
| irq_out | output | 4 | Interrupt lines, each one fed by the channels routed to it |
| wake_req | output | 1 | High while any enabled channel is pending |

## Verification
The inputs are driven with single rising and falling transitions on channels of each polarity. This shows whether the edge selector looks at the right direction, and whether the opposite edge is ignored. Routing is tried with three channels sent to three different lines, which are then cleared one at a time, so that a swapped field or a wrong OR term shows on the wrong line. Other patterns cover timing and setup changes: a level held high through reset, a polarity flip on a steady input, a clear that lands in the same cycle as a new edge, and a sample taken one cycle before and one cycle after the synchronizer delay.

// File: rtl/mwu_pkg.sv
package mwu_pkg;
  typedef enum logic [1:0] {
    REG_ENABLE   = 2'd0,
    REG_POLARITY = 2'd1,
    REG_PENDING  = 2'd2,
    REG_ROUTE    = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/mwu_sync.sv
module mwu_sync #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_i;
      stage2_q <= stage1_q;
    end
  end

  assign sync_o = stage2_q;
endmodule

// File: rtl/mwu_edge.sv
module mwu_edge #(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] level_i,
  input  logic [NUM_CH-1:0] pol_i,
  output logic [NUM_CH-1:0] evt_o
);
  localparam logic [1:0] FILL_DONE = 2'd3;

  logic [NUM_CH-1:0] prev_q;
  logic [1:0]        fill_q;
  logic [1:0]        fill_d;
  logic              ready;

  // Edges count only once the synchronizer and history hold real samples
  assign ready = (fill_q == FILL_DONE);

  always_comb begin
    fill_d = fill_q;
    if (!ready) fill_d = fill_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
      prev_q <= '0;
    end else begin
      fill_q <= fill_d;
      prev_q <= level_i;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic rise;
    logic fall;
    assign rise     = level_i[c] & ~prev_q[c];
    assign fall     = ~level_i[c] & prev_q[c];
    assign evt_o[c] = ready & (pol_i[c] ? fall : rise);
  end

  AST_EVT_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((evt_o & $past(evt_o) & ~(pol_i ^ $past(pol_i))) == '0)); // R2
endmodule

// File: rtl/mwu_regs.sv
module mwu_regs
  import mwu_pkg::*;
#(
  parameter int NUM_CH  = 16,
  parameter int ROUTE_W = 32,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_i,
  input  logic [1:0]         addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [NUM_CH-1:0]  evt_i,
  output logic [NUM_CH-1:0]  en_o,
  output logic [NUM_CH-1:0]  pol_o,
  output logic [NUM_CH-1:0]  pend_o,
  output logic [ROUTE_W-1:0] route_o,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               wake_o
);
  logic [NUM_CH-1:0]  en_q, en_d;
  logic [NUM_CH-1:0]  pol_q, pol_d;
  logic [NUM_CH-1:0]  pend_q, pend_d;
  logic [ROUTE_W-1:0] route_q, route_d;
  logic [NUM_CH-1:0]  clr_mask;
  logic               en_we, pol_we, route_we, pend_we;

  assign en_we    = wr_i && (addr_i == REG_ENABLE);
  assign pol_we   = wr_i && (addr_i == REG_POLARITY);
  assign pend_we  = wr_i && (addr_i == REG_PENDING);
  assign route_we = wr_i && (addr_i == REG_ROUTE);

  always_comb begin
    en_d     = en_q;
    pol_d    = pol_q;
    route_d  = route_q;
    clr_mask = '0;
    if (en_we)    en_d     = wdata_i[NUM_CH-1:0];
    if (pol_we)   pol_d    = wdata_i[NUM_CH-1:0];
    if (route_we) route_d  = wdata_i[ROUTE_W-1:0];
    if (pend_we)  clr_mask = wdata_i[NUM_CH-1:0];
    // a new edge outranks a clear landing in the same cycle
    pend_d = (pend_q & ~clr_mask) | evt_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      pol_q   <= '0;
      route_q <= '0;
      pend_q  <= '0;
    end else begin
      if (en_we)    en_q    <= en_d;
      if (pol_we)   pol_q   <= pol_d;
      if (route_we) route_q <= route_d;
      pend_q <= pend_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      REG_ENABLE:   rdata_o[NUM_CH-1:0]  = en_q;
      REG_POLARITY: rdata_o[NUM_CH-1:0]  = pol_q;
      REG_PENDING:  rdata_o[NUM_CH-1:0]  = pend_q;
      default:      rdata_o[ROUTE_W-1:0] = route_q;
    endcase
  end

  assign en_o    = en_q;
  assign pol_o   = pol_q;
  assign pend_o  = pend_q;
  assign route_o = route_q;
  assign wake_o  = |(en_q & pend_q);

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(pend_q) & ~$past(clr_mask)) & ~pend_q) == '0)); // R7
  AST_PEND_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(evt_i)) == '0)); // R2
endmodule

// File: rtl/mwu_route.sv
module mwu_route #(
  parameter int NUM_CH  = 16,
  parameter int NUM_IRQ = 4,
  parameter int SEL_W   = 2,
  parameter int ROUTE_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CH-1:0]  en_i,
  input  logic [NUM_CH-1:0]  pend_i,
  input  logic [ROUTE_W-1:0] route_i,
  output logic [NUM_IRQ-1:0] irq_o
);
  logic [NUM_CH-1:0] active;
  assign active = en_i & pend_i;

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_line
    logic [NUM_CH-1:0] member;
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign member[c] = (route_i[c*SEL_W +: SEL_W] == SEL_W'(k));
    end
    assign irq_o[k] = |(active & member);
  end

  AST_IRQ_FROM_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o != '0) |-> ((en_i & pend_i) != '0)); // R4
endmodule

// File: rtl/edge_wake_ctrl.sv
module edge_wake_ctrl #(
  parameter int NUM_CH  = 16,
  parameter int NUM_IRQ = 4,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CH-1:0]  ev_in,
  input  logic               reg_wr,
  input  logic [1:0]         reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic [NUM_IRQ-1:0] irq_out,
  output logic               wake_req
);
  localparam int SEL_W   = $clog2(NUM_IRQ);
  localparam int ROUTE_W = NUM_CH * SEL_W;

  logic [NUM_CH-1:0]  lvl;
  logic [NUM_CH-1:0]  evt;
  logic [NUM_CH-1:0]  en;
  logic [NUM_CH-1:0]  pol;
  logic [NUM_CH-1:0]  pend;
  logic [ROUTE_W-1:0] route;

  mwu_sync #(.WIDTH(NUM_CH)) i_sync (
    .clk(clk), .rst_n(rst_n), .async_i(ev_in), .sync_o(lvl)
  );

  mwu_edge #(.NUM_CH(NUM_CH)) i_edge (
    .clk(clk), .rst_n(rst_n), .level_i(lvl), .pol_i(pol), .evt_o(evt)
  );

  mwu_regs #(.NUM_CH(NUM_CH), .ROUTE_W(ROUTE_W), .DATA_W(DATA_W)) i_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .evt_i(evt), .en_o(en), .pol_o(pol),
    .pend_o(pend), .route_o(route), .rdata_o(reg_rdata), .wake_o(wake_req)
  );

  mwu_route #(.NUM_CH(NUM_CH), .NUM_IRQ(NUM_IRQ), .SEL_W(SEL_W), .ROUTE_W(ROUTE_W)) i_route (
    .clk(clk), .rst_n(rst_n), .en_i(en), .pend_i(pend), .route_i(route),
    .irq_o(irq_out)
  );

  AST_WAKE_TRACKS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req == (|irq_out)); // R6
endmodule

// File: tb/test_edge_wake_ctrl.sv
module test_edge_wake_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [15:0] ev_in;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [3:0]  irq_out;
  logic        wake_req;

  int n_checks = 0;
  int n_fail   = 0;

  edge_wake_ctrl i_edge_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .ev_in(ev_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out), .wake_req(wake_req)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse(input int ch);
    ev_in[ch] = 1'b1; tick(4);
    ev_in[ch] = 1'b0; tick(4);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    tick(6);
    for (int a = 0; a < 4; a++) begin
      rd_reg(a[1:0], d);
      check("R1 register reset", d, 32'h0);
    end
    check("R1 irq reset", {28'h0, irq_out}, 32'h0);
    check("R1 wake reset", {31'h0, wake_req}, 32'h0);
    rd_reg(2'd2, d);
    check("R10 level held through reset", d, 32'h0);
    ev_in[5] = 1'b0; tick(5);
    rd_reg(2'd2, d);
    check("R2 falling edge ignored at polarity 0", d, 32'h0);
  endtask

  task automatic t_latency;
    logic [31:0] d;
    wr_reg(2'd0, 32'h0000_FFFF);
    ev_in[0] = 1'b1;
    tick(2);
    rd_reg(2'd2, d);
    check("R11 not yet pending after two edges", d, 32'h0);
    tick(1);
    rd_reg(2'd2, d);
    check("R11 R2 pending after third edge", d, 32'h1);
    check("R5 irq line 0", {28'h0, irq_out}, 32'h1);
    check("R6 wake high", {31'h0, wake_req}, 32'h1);
    ev_in[0] = 1'b0; tick(4);
    wr_reg(2'd2, 32'h1); tick(1);
    rd_reg(2'd2, d);
    check("R7 cleared", d, 32'h0);
    check("R6 wake low", {31'h0, wake_req}, 32'h0);
  endtask

  task automatic t_fall;
    logic [31:0] d;
    wr_reg(2'd1, 32'h0008);
    ev_in[3] = 1'b1; tick(5);
    rd_reg(2'd2, d);
    check("R3 rising ignored at polarity 1", d, 32'h0);
    ev_in[3] = 1'b0; tick(5);
    rd_reg(2'd2, d);
    check("R3 falling recorded", d, 32'h8);
    wr_reg(2'd2, 32'h8);
    wr_reg(2'd1, 32'h0);
  endtask

  task automatic t_disabled;
    logic [31:0] d;
    wr_reg(2'd0, 32'h0000_FF7F);
    pulse(7);
    rd_reg(2'd2, d);
    check("R4 disabled edge recorded", d, 32'h80);
    check("R4 disabled no irq", {28'h0, irq_out}, 32'h0);
    check("R4 disabled no wake", {31'h0, wake_req}, 32'h0);
    wr_reg(2'd0, 32'h0000_FFFF); tick(1);
    check("R4 enable raises irq", {28'h0, irq_out}, 32'h1);
    check("R4 enable raises wake", {31'h0, wake_req}, 32'h1);
    wr_reg(2'd2, 32'h80);
  endtask

  task automatic t_route;
    logic [31:0] d;
    wr_reg(2'd3, 32'h010C_0008);
    rd_reg(2'd3, d);
    check("R5 routing readback", d, 32'h010C_0008);
    pulse(9);
    check("R5 ch9 to line 3", {28'h0, irq_out}, 32'h8);
    check("R6 wake with line 3", {31'h0, wake_req}, 32'h1);
    pulse(12);
    check("R5 ch12 to line 1", {28'h0, irq_out}, 32'hA);
    pulse(1);
    check("R5 ch1 to line 2", {28'h0, irq_out}, 32'hE);
    wr_reg(2'd2, 32'h0200); tick(1);
    check("R5 line 3 drops", {28'h0, irq_out}, 32'h6);
  endtask

  task automatic t_clear;
    logic [31:0] d;
    wr_reg(2'd2, 32'h0); tick(1);
    rd_reg(2'd2, d);
    check("R7 zero write keeps bits", d, 32'h1002);
    wr_reg(2'd2, 32'h0002); tick(1);
    rd_reg(2'd2, d);
    check("R7 partial clear", d, 32'h1000);
    wr_reg(2'd2, 32'h1000); tick(1);
    rd_reg(2'd2, d);
    check("R7 full clear", d, 32'h0);
    check("R6 wake low after clear", {31'h0, wake_req}, 32'h0);
    wr_reg(2'd3, 32'h0);
  endtask

  task automatic t_collide;
    logic [31:0] d;
    ev_in[2] = 1'b1;
    tick(2);
    wr_reg(2'd2, 32'h0004);
    rd_reg(2'd2, d);
    check("R8 edge wins over clear", d, 32'h4);
    wr_reg(2'd2, 32'h0004);
    rd_reg(2'd2, d);
    check("R8 later clear works", d, 32'h0);
    ev_in[2] = 1'b0; tick(4);
  endtask

  task automatic t_polchange;
    logic [31:0] d;
    ev_in[6] = 1'b1; tick(4);
    wr_reg(2'd2, 32'h0040);
    wr_reg(2'd1, 32'h0040); tick(4);
    rd_reg(2'd2, d);
    check("R9 polarity flip on high input", d, 32'h0);
    ev_in[6] = 1'b0; tick(4);
    rd_reg(2'd2, d);
    check("R9 real falling edge after flip", d, 32'h40);
    wr_reg(2'd2, 32'h0040);
    wr_reg(2'd1, 32'h0000); tick(4);
    rd_reg(2'd2, d);
    check("R9 polarity flip on low input", d, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ev_in = 16'h0020; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    tick(3);
    rst_n = 1'b1;
    t_reset();
    t_latency();
    t_fall();
    t_disabled();
    t_route();
    t_clear();
    t_collide();
    t_polchange();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule